// File: doc/BRIEF.md
# Keyed SPI Configuration Register File

This block is a serial slave that holds a bank of 8-bit configuration registers behind a three-wire serial port (clock, data in, data out) plus an active-low select. Every transfer is a fixed 16-bit frame: a 2-bit opcode, a 6-bit register address, then 8 data bits. A read frame returns the addressed register on the data-out line during the data phase. A write frame updates the register at the end of the frame.

The bank is write-protected after every reset. A host must first write the global key value to the key register. Until then, every other write is dropped, but reads still work. The mode register needs a second key, written to its own key register, before it accepts a value. The mode register resets to the normal-operation code. While it holds the alignment code, a dedicated output flag is raised, and writing the normal code clears it.

The port clock runs the whole block. Data in is sampled on the rising edge and data out changes on the falling edge. Select must be high on at least one rising edge between frames.

Top module: `spi_cfg_regfile`

## Requirements
- R1: After reset, every register reads 0x00 except the mode register at address 0x10, which reads 0x01. The alignment flag is low and data out is low.
- R2: A frame is 16 bits, sent MSB first on the data-in line and sampled on rising clock edges while select is low. The fields are opcode[1:0], then address[5:0], then data[7:0]. Opcode 01 writes the data to the address, and the new value is visible on `regs_o` (register n at bits [8n+7:8n]) once the 16th rising edge has occurred.
- R3: For opcode 10, the addressed register is shifted out MSB first on data out. Each bit changes on a falling edge, and the first bit appears on the falling edge after the 8th rising edge. Outside that data phase, data out is low.
- R4: A write to any address other than 0x1B is ignored until 0xEB has been written to address 0x1B. The unlock then lasts until reset. Address 0x1B always accepts writes.
- R5: Reads return register contents whether or not the bank is unlocked.
- R6: The mode register at 0x10 accepts a write only after 0xAB has been written to address 0x11 while the bank was already unlocked.
- R7: The alignment flag is high exactly while the mode register holds 0x11. Writing 0x01 returns the block to normal operation.
- R8: Opcodes 00 and 11 change no register and leave data out low.
- R9: If select rises before the 16th rising edge, the frame is discarded and no register changes. A rising edge with select high restarts the bit count.
- R10: Addresses at or above the bank depth (32 by default) read as 0x00, and writes to them are discarded.
- R11: Rising edges beyond the 16th within one select period are ignored. A frame writes at most once.
- R12: Reset clears both unlocks, so writes are ignored again until the key sequence is repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| spi_clk_i | input | 1 | Serial clock; clocks all logic |
| rst_ni | input | 1 | Asynchronous active-low reset |
| spi_cs_ni | input | 1 | Active-low frame select |
| spi_si_i | input | 1 | Serial data in, sampled on the rising edge |
| spi_so_o | output | 1 | Serial data out, updated on the falling edge |
| regs_o | output | DEPTH*8 | Contents of all registers, register n at bits [8n+7:8n] |
| align_o | output | 1 | High while the mode register holds the alignment code |

## Verification
The hardest state to reach from the ports is a change of the mode register. It needs two keyed writes in the right order, and each protected step has a near-miss that must be shown to have no effect. The stimulus walks the sequence step by step:
- a mode write with the bank locked;
- a mode write after only the global key;
- the full key sequence.

A mid-run reset follows, showing that the protection comes back. Aborted frames, idle opcodes, over-clocked frames and out-of-range addresses are placed between these steps, and each is followed by read-back frames. Because these events are mixed into the key sequence, a design that corrupts state through them would be caught.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    CMD_IDLE0 = 2'b00,
    CMD_WR    = 2'b01,
    CMD_RD    = 2'b10,
    CMD_IDLE3 = 2'b11
  } cmd_e;

  localparam logic [ADDR_W-1:0] ADDR_KEY  = 6'h1B;
  localparam logic [ADDR_W-1:0] ADDR_MKEY = 6'h11;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 6'h10;

  localparam logic [DATA_W-1:0] KEY_VAL    = 8'hEB;
  localparam logic [DATA_W-1:0] MKEY_VAL   = 8'hAB;
  localparam logic [DATA_W-1:0] MODE_ALIGN = 8'h11;
  localparam logic [DATA_W-1:0] MODE_NORM  = 8'h01;
endpackage

// File: rtl/spi_cfg_frame.sv
module spi_cfg_frame
  import spi_cfg_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          si_i,
  output logic          so_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  localparam int HDR_W     = 2 + AW;
  localparam int FRAME_LEN = HDR_W + DW;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam int SR_W      = (HDR_W > DW) ? HDR_W - 1 : DW - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [SR_W-1:0]  sr_q;
  logic [HDR_W-1:0] hdr_q;
  logic [DW-1:0]    rd_sr_q;
  logic             so_q;

  logic [HDR_W-1:0] hdr_now;
  logic [DW-1:0]    word_now;
  logic             hdr_done, last_bit, data_phase, rd_phase;
  cmd_e             cmd;

  assign hdr_now    = {sr_q[HDR_W-2:0], si_i};
  assign word_now   = {sr_q[DW-2:0], si_i};
  assign hdr_done   = !cs_ni && (cnt_q == CNT_W'(HDR_W - 1));
  assign last_bit   = !cs_ni && (cnt_q == CNT_W'(FRAME_LEN - 1));
  assign data_phase = (cnt_q >= CNT_W'(HDR_W)) && (cnt_q < CNT_W'(FRAME_LEN));
  assign cmd        = cmd_e'(hdr_q[HDR_W-1 -: 2]);
  assign rd_phase   = !cs_ni && data_phase && (cmd == CMD_RD);

  assign rd_addr_o = hdr_now[AW-1:0];
  assign wr_en_o   = last_bit && (cmd == CMD_WR);
  assign wr_addr_o = hdr_q[AW-1:0];
  assign wr_data_o = word_now;
  assign so_o      = so_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sr_q    <= '0;
      hdr_q   <= '0;
      rd_sr_q <= '0;
    end else if (cs_ni) begin
      cnt_q <= '0;
    end else begin
      sr_q <= {sr_q[SR_W-2:0], si_i};
      if (cnt_q != CNT_W'(FRAME_LEN)) cnt_q <= cnt_q + 1'b1;
      if (hdr_done) begin
        hdr_q   <= hdr_now;
        rd_sr_q <= rd_data_i;
      end else if (data_phase) begin
        rd_sr_q <= {rd_sr_q[DW-2:0], 1'b0};
      end
    end
  end

  // launch on the falling edge so the master samples mid-bit
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) so_q <= 1'b0;
    else         so_q <= rd_phase ? rd_sr_q[DW-1] : 1'b0;
  end
endmodule

// File: rtl/spi_cfg_bank.sv
module spi_cfg_bank
  import spi_cfg_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = ADDR_W,
  parameter int DW    = DATA_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       wr_addr_i,
  input  logic [DW-1:0]       wr_data_i,
  input  logic [AW-1:0]       rd_addr_i,
  output logic [DW-1:0]       rd_data_o,
  output logic [DEPTH*DW-1:0] regs_o,
  output logic                glob_unl_o,
  output logic                mode_unl_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic glob_q, mode_q;
  logic [DEPTH-1:0][DW-1:0] arr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glob_q <= 1'b0;
      mode_q <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_KEY && wr_data_i == KEY_VAL) glob_q <= 1'b1;
      if (glob_q && wr_addr_i == ADDR_MKEY && wr_data_i == MKEY_VAL) mode_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    localparam bit IS_KEY  = (g == int'(ADDR_KEY));
    localparam bit IS_MODE = (g == int'(ADDR_MODE));
    localparam logic [DW-1:0] RST_VAL = IS_MODE ? DW'(MODE_NORM) : '0;

    logic          allow;
    logic [DW-1:0] q;

    if (IS_KEY) begin : g_key
      assign allow = 1'b1;
    end else if (IS_MODE) begin : g_mode
      assign allow = glob_q & mode_q;
    end else begin : g_plain
      assign allow = glob_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= RST_VAL;
      else if (wr_en_i && allow && wr_addr_i == AW'(g)) q <= wr_data_i;
    end

    assign arr[g] = q;
  end

  assign regs_o     = arr;
  assign glob_unl_o = glob_q;
  assign mode_unl_o = mode_q;
  assign rd_data_o  = (int'(rd_addr_i) < DEPTH) ? arr[rd_addr_i[IDX_W-1:0]] : '0;
endmodule

// File: rtl/spi_cfg_regfile.sv
module spi_cfg_regfile
  import spi_cfg_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                    spi_clk_i,
  input  logic                    rst_ni,
  input  logic                    spi_cs_ni,
  input  logic                    spi_si_i,
  output logic                    spi_so_o,
  output logic [DEPTH*DATA_W-1:0] regs_o,
  output logic                    align_o
);
  localparam int MODE_IDX = int'(ADDR_MODE);

  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_en, glob_unl, mode_unl;

  spi_cfg_frame #(.AW(ADDR_W), .DW(DATA_W)) u_frame (
    .clk_i     (spi_clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (spi_cs_ni),
    .si_i      (spi_si_i),
    .so_o      (spi_so_o),
    .rd_addr_o (rd_addr),
    .rd_data_i (rd_data),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data)
  );

  spi_cfg_bank #(.DEPTH(DEPTH), .AW(ADDR_W), .DW(DATA_W)) u_bank (
    .clk_i      (spi_clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data),
    .regs_o     (regs_o),
    .glob_unl_o (glob_unl),
    .mode_unl_o (mode_unl)
  );

  assign align_o = (regs_o[MODE_IDX*DATA_W +: DATA_W] == MODE_ALIGN);
endmodule

// File: rtl/spi_cfg_regfile_chk.sv
module spi_cfg_regfile_chk #(
  parameter int DEPTH = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cs_ni_i,
  input logic               so_i,
  input logic               wr_en_i,
  input logic               glob_unl_i,
  input logic               mode_unl_i,
  input logic [DEPTH*8-1:0] regs_i,
  input logic               align_i
);
  assert_locked_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glob_unl_i |=> $stable(regs_i[7:0]));

  assert_mode_guard_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_unl_i |=> $stable(regs_i[16*8 +: 8]));

  assert_align_keyed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(align_i) |-> mode_unl_i);

  assert_so_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cs_ni_i) && cs_ni_i) |-> !so_i);

  assert_write_selected_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !cs_ni_i);

  assert_single_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !wr_en_i);
endmodule

bind spi_cfg_regfile spi_cfg_regfile_chk #(.DEPTH(DEPTH)) chk_i (
  .clk_i      (spi_clk_i),
  .rst_ni     (rst_ni),
  .cs_ni_i    (spi_cs_ni),
  .so_i       (spi_so_o),
  .wr_en_i    (wr_en),
  .glob_unl_i (glob_unl),
  .mode_unl_i (mode_unl),
  .regs_i     (regs_o),
  .align_i    (align_o)
);

// File: tb/spi_cfg_regfile_tb_top.sv
module spi_cfg_regfile_tb_top;
  localparam int CLK_P = 10;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_n = 1'b1;
  logic si = 1'b0;
  logic so;
  logic [DEPTH*8-1:0] regs;
  logic align;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_regs [DEPTH];
  bit g_unl, m_unl;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] obs_byte;
  event       rd_ev;

  always #(CLK_P/2) clk = ~clk;

  spi_cfg_regfile #(.DEPTH(DEPTH)) dut_i (
    .spi_clk_i (clk),
    .rst_ni    (rst_ni),
    .spi_cs_ni (cs_n),
    .spi_si_i  (si),
    .spi_so_o  (so),
    .regs_o    (regs),
    .align_o   (align)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DEPTH*8-1:0] model_flat();
    logic [DEPTH*8-1:0] v;
    for (int i = 0; i < DEPTH; i++) v[i*8 +: 8] = m_regs[i];
    return v;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) m_regs[i] = 8'h00;
    m_regs[16] = 8'h01;
    g_unl = 0;
    m_unl = 0;
  endtask

  task automatic model_write(input logic [5:0] a, input logic [7:0] d);
    bit g_old = g_unl;
    if (a == 6'h1B && d == 8'hEB) g_unl = 1;
    if (g_old && a == 6'h11 && d == 8'hAB) m_unl = 1;
    if (int'(a) < DEPTH) begin
      if (a == 6'h1B || (g_old && (a != 6'h10 || m_unl))) m_regs[a] = d;
    end
  endtask

  // driver: one frame of nbits clocks; read frames push an expected byte
  task automatic xfer(input logic [1:0] cmd, input logic [5:0] a, input logic [7:0] d,
                      input int nbits, input string req);
    logic [15:0] w = {cmd, a, d};
    logic [7:0] cap = '0;
    bit hdr_quiet = 1;
    if (cmd == 2'b10) begin
      exp_q.push_back((int'(a) < DEPTH) ? m_regs[a] : 8'h00);
      tag_q.push_back(req);
    end
    @(negedge clk); #1;
    cs_n = 1'b0;
    si = w[15];
    for (int b = 1; b < nbits + 1; b++) begin
      @(negedge clk); #1;
      if (b >= 8 && b <= 15 && cmd == 2'b10) cap[15-b] = so;
      else if (so !== 1'b0) hdr_quiet = 0;
      si = (b < 16) ? w[15-b] : 1'b1;
      if (b == nbits) begin
        cs_n = 1'b1;
        si = 1'b0;
      end
    end
    check({"R3 data out idle outside read data ", req}, 64'(hdr_quiet), 64'd1);
    if (nbits >= 16 && cmd == 2'b01) model_write(a, d);
    if (cmd == 2'b10) begin
      obs_byte = cap;
      -> rd_ev;
    end
  endtask

  // monitor: compare each shifted-out byte with the queued expectation
  initial begin
    forever begin
      @(rd_ev);
      check({"R3 read ", tag_q.pop_front()}, 64'(obs_byte), 64'(exp_q.pop_front()));
    end
  end

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk); #1;
    check("R1 reset regs", 64'(regs[16*8 +: 8]), 64'h01);
    check("R1 reset full bank", 64'(regs == model_flat()), 64'd1);
    check("R1 reset align", 64'(align), 64'd0);
    check("R1 reset so", 64'(so), 64'd0);

    xfer(2'b10, 6'h10, 8'h00, 16, "R5 mode while locked");
    xfer(2'b01, 6'h00, 8'h55, 16, "R4 locked write");
    check("R4 locked write ignored", 64'(regs[7:0]), 64'h00);
    xfer(2'b01, 6'h10, 8'h11, 16, "R6 mode write locked");
    check("R6 align stays low", 64'(align), 64'd0);

    xfer(2'b01, 6'h1B, 8'hEB, 16, "R4 key");
    xfer(2'b10, 6'h1B, 8'h00, 16, "R4 key readback");
    xfer(2'b01, 6'h00, 8'h5A, 16, "R2 write");
    check("R2 reg0 written", 64'(regs[7:0]), 64'h5A);
    xfer(2'b10, 6'h00, 8'h00, 16, "R2 reg0 readback");
    xfer(2'b01, 6'h05, 8'hC3, 16, "R2 write reg5");
    xfer(2'b10, 6'h05, 8'h00, 16, "R2 reg5 readback");

    xfer(2'b01, 6'h10, 8'h11, 16, "R6 mode without mode key");
    check("R6 mode unchanged", 64'(regs[16*8 +: 8]), 64'h01);
    xfer(2'b01, 6'h11, 8'hAB, 16, "R6 mode key");
    xfer(2'b01, 6'h10, 8'h11, 16, "R7 enter align");
    check("R7 align high", 64'(align), 64'd1);
    xfer(2'b10, 6'h10, 8'h00, 16, "R7 mode readback");

    xfer(2'b01, 6'h00, 8'hFF, 12, "R9 aborted");
    check("R9 aborted frame no change", 64'(regs == model_flat()), 64'd1);
    xfer(2'b01, 6'h00, 8'hFF, 15, "R9 aborted late");
    check("R9 late abort no change", 64'(regs[7:0]), 64'h5A);
    xfer(2'b00, 6'h00, 8'h12, 16, "R8 op00");
    xfer(2'b11, 6'h05, 8'h34, 16, "R8 op11");
    check("R8 idle ops no change", 64'(regs == model_flat()), 64'd1);

    xfer(2'b01, 6'h25, 8'h3C, 16, "R10 high write");
    check("R10 bank unchanged", 64'(regs == model_flat()), 64'd1);
    xfer(2'b10, 6'h25, 8'h00, 16, "R10 high read");

    xfer(2'b01, 6'h07, 8'h96, 21, "R11 extra clocks");
    check("R11 reg7 first byte only", 64'(regs[7*8 +: 8]), 64'h96);
    xfer(2'b10, 6'h07, 8'h00, 20, "R11 extra clocks read");

    xfer(2'b01, 6'h10, 8'h01, 16, "R7 leave align");
    check("R7 align low", 64'(align), 64'd0);

    @(negedge clk); #1 rst_ni = 1'b0;
    model_reset();
    @(negedge clk); #1 rst_ni = 1'b1;
    check("R12 reset restores bank", 64'(regs == model_flat()), 64'd1);
    xfer(2'b01, 6'h00, 8'h77, 16, "R12 relocked write");
    check("R12 write ignored after reset", 64'(regs[7:0]), 64'h00);
    xfer(2'b01, 6'h11, 8'hAB, 16, "R12 mode key while locked");
    xfer(2'b01, 6'h1B, 8'hEB, 16, "R12 key again");
    xfer(2'b01, 6'h10, 8'h11, 16, "R12 mode key not kept");
    check("R12 align stays low", 64'(align), 64'd0);
    check("R12 bank matches", 64'(regs == model_flat()), 64'd1);

    repeat (4) @(negedge clk);
    check("R3 all reads consumed", 64'(exp_q.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule